// File: doc/BRIEF.md
# NAND Command Decoder with Status Register

This block is the device-side command front end of a NAND memory model. Each write cycle on the 8-bit bus is latched on the rising edge of the active-low write strobe. The command-latch and address-latch enables mark the cycle as a command, an address or a data cycle. The decoder follows three sequences: single-page program, two-plane program and block erase. For each accepted operation it starts a countdown timer that stands in for the internal busy time. While the timer runs, the active-high ready/busy output is held low.

A status register carries a ready bit and a pass/fail bit. After a status-read command, every read strobe (falling edge of the active-low read strobe) returns a snapshot of this register. This continues until another command replaces the status mode. The program or erase result is not computed here. Instead, a two-bit test input gives a per-plane fail flag, and the block samples it when the busy period ends.

While an operation runs, only the two status-read commands and reset are acted on. A two-plane program inserts a short dummy-busy phase between the two page loads, and status reads work during that phase too.

Top module: `nand_cmd_status`

## Requirements
- R1: After reset, rb_n is 1, status mode is off (a read returns 00h), and once a status command is written a read returns 40h.
- R2: The sequence 80h, five address cycles, any number of data cycles, then 10h holds rb_n low for exactly PROG_CYCLES clock cycles, starting right after the clock edge that latches 10h. The page's plane is bit PLANE_BIT (6) of the third address cycle. At the end, the fail bit takes fail_inj[plane].
- R3: The sequence 60h, three address cycles, then D0h holds rb_n low for exactly ERASE_CYCLES cycles, starting right after the edge that latches D0h. The plane is bit 6 of the first address cycle, and the fail bit takes fail_inj[plane].
- R4: After 70h or 78h, every read returns the status byte: bit 6 is ready (1 = ready), bit 0 is the fail result of the last completed program or erase, and all other bits are 0.
- R5: While busy, address cycles, data cycles and every command other than 70h, 78h and FFh are ignored. The busy length is unchanged and the status mode is kept.
- R6: A status read taken while busy returns bit 6 = 0, and bit 0 still holds the previous result.
- R7: In a two-plane program, 80h, five addresses (plane 0), data, then 11h gives a dummy busy of DBSY_CYCLES cycles. Then 80h or 81h, five addresses (plane 1), data, then 10h gives a busy of PROG_CYCLES cycles. The fail bit becomes fail_inj[0] OR fail_inj[1].
- R8: Status reads during the dummy busy return bit 6 = 0.
- R9: If 11h follows a first page whose plane bit is 1, or 10h follows a second page whose plane bit is 0, the sequence is aborted and no busy period starts.
- R10: An unexpected command byte, or a cycle of the wrong kind, in the middle of a sequence returns the decoder to idle without starting an operation. A status command used this way also enters status mode.
- R11: FFh, accepted in any state including busy, makes rb_n 1 on the next cycle, clears the fail bit and leaves status mode.
- R12: When not busy, any command other than 70h or 78h ends status mode, so reads return 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cle | input | 1 | Command-latch enable |
| ale | input | 1 | Address-latch enable |
| we_n | input | 1 | Active-low write strobe; a cycle is latched on its rising edge |
| re_n | input | 1 | Active-low read strobe; output updated on its falling edge |
| io_in | input | 8 | Write bus |
| fail_inj | input | 2 | Injected fail flag per plane, sampled at the end of busy |
| rb_n | output | 1 | Ready (1) / busy (0) |
| io_out | output | 8 | Read data: the status byte in status mode, else 00h |

## Verification
A decoder that is stuck in the wrong sequence state shows up in two ways. A confirm byte may fail to pull rb_n low on the cycle after its write edge, or a stray byte may start a busy period, so a wrong transition appears on rb_n within one clock. A timer that was reloaded or mis-cleared changes the measured busy length, which the bench compares exactly against the configured count. A lost status mode or a wrong fail latch appears on the next read strobe as a wrong byte.

// File: rtl/nand_cmd_pkg.sv
package nand_cmd_pkg;

    localparam logic [7:0] OP_LOAD     = 8'h80;
    localparam logic [7:0] OP_LOAD_ALT = 8'h81;
    localparam logic [7:0] OP_GO       = 8'h10;
    localparam logic [7:0] OP_SPLIT    = 8'h11;
    localparam logic [7:0] OP_ERASE    = 8'h60;
    localparam logic [7:0] OP_ERASE_GO = 8'hD0;
    localparam logic [7:0] OP_STAT_A   = 8'h70;
    localparam logic [7:0] OP_STAT_B   = 8'h78;
    localparam logic [7:0] OP_RESET    = 8'hFF;

    typedef enum logic [1:0] {
        CY_NONE,
        CY_CMD,
        CY_ADDR,
        CY_DATA
    } cyc_kind_t;

    typedef struct packed {
        cyc_kind_t  kind;
        logic [7:0] val;
    } bus_cyc_t;

    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_P1_ADDR,
        SQ_P1_DATA,
        SQ_DUMMY,
        SQ_P2_CMD,
        SQ_P2_ADDR,
        SQ_P2_DATA,
        SQ_E_ADDR,
        SQ_E_CONF,
        SQ_PROG,
        SQ_ERASE
    } seq_state_t;

    typedef enum logic [1:0] {
        TM_NONE,
        TM_PROG,
        TM_ERASE,
        TM_DUMMY
    } tm_op_t;

    function automatic logic is_status_op(input logic [7:0] b);
        return (b == OP_STAT_A) || (b == OP_STAT_B);
    endfunction

    function automatic logic [7:0] status_byte(input logic rdy, input logic fl);
        return {1'b0, rdy, 5'b00000, fl};
    endfunction

endpackage

// File: rtl/nand_strobe_edge.sv
module nand_strobe_edge #(
    parameter bit RISING = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic evt
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= pin;
    end

    generate
        if (RISING) begin : g_rise
            assign evt = pin & ~prev_q;
        end else begin : g_fall
            assign evt = ~pin & prev_q;
        end
    endgenerate
endmodule

// File: rtl/nand_cycle_classify.sv
module nand_cycle_classify
    import nand_cmd_pkg::*;
(
    input  logic       wr_evt,
    input  logic       cle,
    input  logic       ale,
    input  logic [7:0] io_in,
    output bus_cyc_t   cyc
);
    always_comb begin
        cyc.val  = io_in;
        cyc.kind = CY_NONE;
        if (wr_evt) begin
            unique case ({cle, ale})
                2'b10:   cyc.kind = CY_CMD;
                2'b01:   cyc.kind = CY_ADDR;
                2'b00:   cyc.kind = CY_DATA;
                default: cyc.kind = CY_NONE;
            endcase
        end
    end
endmodule

// File: rtl/nand_busy_timer.sv
module nand_busy_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         clear,
    output logic         busy,
    output logic         done
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear)     cnt_q <= '0;
        else if (load)        cnt_q <= load_val;
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);
    assign done = (cnt_q == W'(1));
endmodule

// File: rtl/nand_seq_ctrl.sv
module nand_seq_ctrl
    import nand_cmd_pkg::*;
#(
    parameter int PLANE_BIT = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  bus_cyc_t   cyc,
    input  logic       tmr_done,
    input  logic [1:0] fail_inj,
    output tm_op_t     tm_start,
    output logic       tm_clear,
    output logic       stat_mode,
    output logic       fail_flag
);
    seq_state_t st_q, st_d;
    logic [2:0] acnt_q, acnt_d;
    logic       pla_q, pla_d;
    logic       plb_q, plb_d;
    logic       dual_q, dual_d;
    logic       stat_q, stat_d;
    logic       fail_q, fail_d;
    logic       in_busy;
    logic       is_cmd;
    logic [7:0] b;

    assign b       = cyc.val;
    assign is_cmd  = (cyc.kind == CY_CMD);
    assign in_busy = (st_q == SQ_DUMMY) || (st_q == SQ_PROG) || (st_q == SQ_ERASE);

    always_comb begin
        st_d     = st_q;
        acnt_d   = acnt_q;
        pla_d    = pla_q;
        plb_d    = plb_q;
        dual_d   = dual_q;
        stat_d   = stat_q;
        fail_d   = fail_q;
        tm_start = TM_NONE;
        tm_clear = 1'b0;

        if (is_cmd && b == OP_RESET) begin
            st_d     = SQ_IDLE;
            acnt_d   = '0;
            tm_clear = 1'b1;
            fail_d   = 1'b0;
            stat_d   = 1'b0;
        end else if (in_busy) begin
            if (is_cmd && is_status_op(b)) stat_d = 1'b1;
            if (tmr_done) begin
                unique case (st_q)
                    SQ_DUMMY: st_d = SQ_P2_CMD;
                    SQ_PROG: begin
                        fail_d = dual_q ? (fail_inj[0] | fail_inj[1]) : fail_inj[pla_q];
                        st_d   = SQ_IDLE;
                    end
                    default: begin
                        fail_d = fail_inj[pla_q];
                        st_d   = SQ_IDLE;
                    end
                endcase
            end
        end else if (is_cmd) begin
            if (is_status_op(b)) begin
                stat_d = 1'b1;
                st_d   = SQ_IDLE;
            end else begin
                stat_d = 1'b0;
                unique case (st_q)
                    SQ_IDLE: begin
                        acnt_d = '0;
                        if (b == OP_LOAD) begin
                            st_d   = SQ_P1_ADDR;
                            dual_d = 1'b0;
                        end else if (b == OP_ERASE) begin
                            st_d = SQ_E_ADDR;
                        end
                    end
                    SQ_P1_DATA: begin
                        if (b == OP_GO) begin
                            st_d     = SQ_PROG;
                            tm_start = TM_PROG;
                        end else if (b == OP_SPLIT && !pla_q) begin
                            st_d     = SQ_DUMMY;
                            dual_d   = 1'b1;
                            tm_start = TM_DUMMY;
                        end else begin
                            st_d = SQ_IDLE;
                        end
                    end
                    SQ_P2_CMD: begin
                        if (b == OP_LOAD || b == OP_LOAD_ALT) begin
                            st_d   = SQ_P2_ADDR;
                            acnt_d = '0;
                        end else begin
                            st_d = SQ_IDLE;
                        end
                    end
                    SQ_P2_DATA: begin
                        if (b == OP_GO && plb_q) begin
                            st_d     = SQ_PROG;
                            tm_start = TM_PROG;
                        end else begin
                            st_d = SQ_IDLE;
                        end
                    end
                    SQ_E_CONF: begin
                        if (b == OP_ERASE_GO) begin
                            st_d     = SQ_ERASE;
                            tm_start = TM_ERASE;
                        end else begin
                            st_d = SQ_IDLE;
                        end
                    end
                    default: st_d = SQ_IDLE;
                endcase
            end
        end else if (cyc.kind == CY_ADDR) begin
            unique case (st_q)
                SQ_IDLE: ;
                SQ_P1_ADDR: begin
                    if (acnt_q == 3'd2) pla_d = b[PLANE_BIT];
                    acnt_d = acnt_q + 3'd1;
                    if (acnt_q == 3'd4) st_d = SQ_P1_DATA;
                end
                SQ_P2_ADDR: begin
                    if (acnt_q == 3'd2) plb_d = b[PLANE_BIT];
                    acnt_d = acnt_q + 3'd1;
                    if (acnt_q == 3'd4) st_d = SQ_P2_DATA;
                end
                SQ_E_ADDR: begin
                    if (acnt_q == 3'd0) pla_d = b[PLANE_BIT];
                    acnt_d = acnt_q + 3'd1;
                    if (acnt_q == 3'd2) st_d = SQ_E_CONF;
                end
                default: st_d = SQ_IDLE;
            endcase
        end else if (cyc.kind == CY_DATA) begin
            unique case (st_q)
                SQ_IDLE, SQ_P1_DATA, SQ_P2_DATA: ;
                default: st_d = SQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= SQ_IDLE;
            acnt_q <= '0;
            pla_q  <= 1'b0;
            plb_q  <= 1'b0;
            dual_q <= 1'b0;
            stat_q <= 1'b0;
            fail_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            acnt_q <= acnt_d;
            pla_q  <= pla_d;
            plb_q  <= plb_d;
            dual_q <= dual_d;
            stat_q <= stat_d;
            fail_q <= fail_d;
        end
    end

    assign stat_mode = stat_q;
    assign fail_flag = fail_q;
endmodule

// File: rtl/nand_cmd_status.sv
module nand_cmd_status
    import nand_cmd_pkg::*;
#(
    parameter int PROG_CYCLES  = 20,
    parameter int ERASE_CYCLES = 60,
    parameter int DBSY_CYCLES  = 8,
    parameter int PLANE_BIT    = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cle,
    input  logic       ale,
    input  logic       we_n,
    input  logic       re_n,
    input  logic [7:0] io_in,
    input  logic [1:0] fail_inj,
    output logic       rb_n,
    output logic [7:0] io_out
);
    localparam int MAXC = (PROG_CYCLES > ERASE_CYCLES)
                        ? ((PROG_CYCLES > DBSY_CYCLES) ? PROG_CYCLES : DBSY_CYCLES)
                        : ((ERASE_CYCLES > DBSY_CYCLES) ? ERASE_CYCLES : DBSY_CYCLES);
    localparam int TW = $clog2(MAXC + 1);

    logic     wr_evt, rd_evt;
    bus_cyc_t cyc;
    tm_op_t   tm_start;
    logic     tm_clear, tm_busy, tm_done;
    logic     stat_mode, fail_flag;
    logic [TW-1:0] tm_val;
    logic [7:0]    out_q;

    nand_strobe_edge #(.RISING(1'b1)) u_we (.clk(clk), .rst(rst), .pin(we_n), .evt(wr_evt));
    nand_strobe_edge #(.RISING(1'b0)) u_re (.clk(clk), .rst(rst), .pin(re_n), .evt(rd_evt));

    nand_cycle_classify u_cls (.wr_evt(wr_evt), .cle(cle), .ale(ale), .io_in(io_in), .cyc(cyc));

    nand_seq_ctrl #(.PLANE_BIT(PLANE_BIT)) u_seq (
        .clk(clk), .rst(rst), .cyc(cyc), .tmr_done(tm_done), .fail_inj(fail_inj),
        .tm_start(tm_start), .tm_clear(tm_clear), .stat_mode(stat_mode), .fail_flag(fail_flag)
    );

    always_comb begin
        unique case (tm_start)
            TM_PROG:  tm_val = TW'(PROG_CYCLES);
            TM_ERASE: tm_val = TW'(ERASE_CYCLES);
            TM_DUMMY: tm_val = TW'(DBSY_CYCLES);
            default:  tm_val = '0;
        endcase
    end

    nand_busy_timer #(.W(TW)) u_tmr (
        .clk(clk), .rst(rst), .load(tm_start != TM_NONE), .load_val(tm_val),
        .clear(tm_clear), .busy(tm_busy), .done(tm_done)
    );

    always_ff @(posedge clk) begin
        if (rst)         out_q <= 8'h00;
        else if (rd_evt) out_q <= stat_mode ? status_byte(!tm_busy, fail_flag) : 8'h00;
    end

    assign rb_n   = !tm_busy;
    assign io_out = out_q;
endmodule

// File: rtl/nand_cmd_status_chk.sv
module nand_cmd_status_chk #(
    parameter int PROG_CYCLES  = 20,
    parameter int ERASE_CYCLES = 60,
    parameter int DBSY_CYCLES  = 8
) (
    input logic       clk,
    input logic       rst,
    input logic       cle,
    input logic       ale,
    input logic       we_n,
    input logic       re_n,
    input logic [7:0] io_in,
    input logic       rb_n,
    input logic [7:0] io_out
);
    localparam int MAXC = (PROG_CYCLES > ERASE_CYCLES)
                        ? ((PROG_CYCLES > DBSY_CYCLES) ? PROG_CYCLES : DBSY_CYCLES)
                        : ((ERASE_CYCLES > DBSY_CYCLES) ? ERASE_CYCLES : DBSY_CYCLES);
    localparam int LW = $clog2(MAXC + 2) + 1;

    logic we_q, re_q;
    logic [LW-1:0] low_cnt;
    logic cmd_wr, rd_fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            we_q    <= 1'b1;
            re_q    <= 1'b1;
            low_cnt <= '0;
        end else begin
            we_q    <= we_n;
            re_q    <= re_n;
            low_cnt <= rb_n ? '0 : low_cnt + 1'b1;
        end
    end

    assign cmd_wr  = we_n && !we_q && cle && !ale;
    assign rd_fall = !re_n && re_q;

    // R11: reset command leaves the block ready
    a_r11_reset_ready: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && io_in == 8'hFF) |=> rb_n);

    // R10: busy only ever starts from a confirm byte
    a_r10_busy_from_confirm: assert property (@(posedge clk) disable iff (rst)
        $fell(rb_n) |-> $past(cmd_wr && (io_in == 8'h10 || io_in == 8'h11 || io_in == 8'hD0)));

    // R4: reserved status bits stay zero
    a_r4_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (io_out[7] == 1'b0) && (io_out[5:1] == 5'b0));

    // R6: ready bit in a status snapshot matches the ready pin at read time
    a_r6_ready_bit: assert property (@(posedge clk) disable iff (rst)
        ($past(rd_fall) && io_out != 8'h00) |-> (io_out[6] == $past(rb_n)));

    // R5: no busy period outlasts the longest configured count
    a_r5_busy_bounded: assert property (@(posedge clk) disable iff (rst)
        low_cnt <= LW'(MAXC));
endmodule

bind nand_cmd_status nand_cmd_status_chk #(
    .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES), .DBSY_CYCLES(DBSY_CYCLES)
) u_chk (
    .clk(clk), .rst(rst), .cle(cle), .ale(ale), .we_n(we_n), .re_n(re_n),
    .io_in(io_in), .rb_n(rb_n), .io_out(io_out)
);

// File: tb/sim_nand_cmd_status.sv
module sim_nand_cmd_status;
    localparam int PROG  = 20;
    localparam int ERASE = 60;
    localparam int DBSY  = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1;
    logic [7:0] io_in = 8'h00;
    logic [1:0] fail_inj = 2'b00;
    logic rb_n;
    logic [7:0] io_out;

    int checks = 0;
    int errors = 0;
    longint cyc = 0;
    logic exp_fail = 1'b0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    nand_cmd_status #(.PROG_CYCLES(PROG), .ERASE_CYCLES(ERASE), .DBSY_CYCLES(DBSY), .PLANE_BIT(6)) u0 (
        .clk(clk), .rst(rst), .cle(cle), .ale(ale), .we_n(we_n), .re_n(re_n),
        .io_in(io_in), .fail_inj(fail_inj), .rb_n(rb_n), .io_out(io_out)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic c, input logic a, input logic [7:0] v);
        @(negedge clk);
        cle = c; ale = a; io_in = v; we_n = 1'b0;
        @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
        cle = 1'b0; ale = 1'b0;
    endtask

    task automatic cmd(input logic [7:0] v); wr(1'b1, 1'b0, v); endtask
    task automatic adr(input logic [7:0] v); wr(1'b0, 1'b1, v); endtask
    task automatic dat(input logic [7:0] v); wr(1'b0, 1'b0, v); endtask

    task automatic rd(output logic [7:0] v);
        @(negedge clk);
        re_n = 1'b0;
        @(negedge clk);
        v = io_out;
        re_n = 1'b1;
    endtask

    task automatic wait_rdy(input longint t0, output longint dur);
        while (!rb_n) @(negedge clk);
        dur = cyc - t0;
    endtask

    task automatic page_load(input logic pl);
        adr(8'h00); adr(8'h00); adr({1'b0, pl, 6'h05}); adr(8'h01); adr(8'h00);
        dat(8'hA5); dat(8'h5A);
    endtask

    function automatic logic [7:0] sbyte(input logic rdy, input logic fl);
        return {1'b0, rdy, 5'b0, fl};
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [7:0] v;
        longint t0, dur;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check(rb_n == 1'b1, "R1 ready after reset", rb_n, 1);
        rd(v);  check(v == 8'h00, "R1 read without status mode", v, 8'h00);
        cmd(8'h70); rd(v); check(v == 8'h40, "R1 R4 status after reset", v, 8'h40);

        // R2 single-page program sweep over plane and injected fail
        for (int pl = 0; pl < 2; pl++) begin
            for (int f = 0; f < 4; f++) begin
                fail_inj = 2'(f);
                cmd(8'h80); page_load(1'(pl)); cmd(8'h10); t0 = cyc;
                check(rb_n == 1'b0, "R2 busy after confirm", rb_n, 0);
                cmd(8'h70); rd(v);
                check(v == sbyte(1'b0, exp_fail), "R6 status while busy", v, sbyte(1'b0, exp_fail));
                wait_rdy(t0, dur);
                check(dur == PROG, "R2 program busy length", dur, PROG);
                exp_fail = f[pl];
                rd(v);
                check(v == sbyte(1'b1, exp_fail), "R2 R4 program result", v, sbyte(1'b1, exp_fail));
            end
        end

        // R3 erase sweep
        for (int pl = 0; pl < 2; pl++) begin
            for (int f = 0; f < 4; f++) begin
                fail_inj = 2'(f);
                cmd(8'h60); adr({1'b0, 1'(pl), 6'h11}); adr(8'h22); adr(8'h00);
                cmd(8'hD0); t0 = cyc;
                check(rb_n == 1'b0, "R3 busy after erase confirm", rb_n, 0);
                wait_rdy(t0, dur);
                check(dur == ERASE, "R3 erase busy length", dur, ERASE);
                exp_fail = f[pl];
                cmd(8'h78); rd(v);
                check(v == sbyte(1'b1, exp_fail), "R3 R4 erase result via 78h", v, sbyte(1'b1, exp_fail));
            end
        end

        // R7 R8 two-plane program sweep
        for (int k = 0; k < 2; k++) begin
            for (int f = 0; f < 4; f++) begin
                fail_inj = 2'(f);
                cmd(8'h80); page_load(1'b0); cmd(8'h11); t0 = cyc;
                cmd(8'h70); rd(v);
                check(v[6] == 1'b0, "R8 status during dummy busy", v, sbyte(1'b0, exp_fail));
                wait_rdy(t0, dur);
                check(dur == DBSY, "R7 dummy busy length", dur, DBSY);
                cmd(k == 0 ? 8'h81 : 8'h80); page_load(1'b1); cmd(8'h10); t0 = cyc;
                wait_rdy(t0, dur);
                check(dur == PROG, "R7 dual program busy length", dur, PROG);
                exp_fail = f[0] | f[1];
                cmd(8'h70); rd(v);
                check(v == sbyte(1'b1, exp_fail), "R7 combined fail", v, sbyte(1'b1, exp_fail));
            end
        end

        // R9 plane rule
        cmd(8'h80); page_load(1'b1); cmd(8'h11);
        check(rb_n == 1'b1, "R9 first page on plane 1 rejected", rb_n, 1);
        cmd(8'h10);
        check(rb_n == 1'b1, "R9 no start after rejected split", rb_n, 1);
        cmd(8'h80); page_load(1'b0); cmd(8'h11); t0 = cyc; wait_rdy(t0, dur);
        cmd(8'h81); page_load(1'b0); cmd(8'h10);
        check(rb_n == 1'b1, "R9 second page on plane 0 rejected", rb_n, 1);

        // R10 aborts
        cmd(8'h80); adr(8'h00); adr(8'h00); cmd(8'h60);
        adr(8'h00); adr(8'h00); adr(8'h00); cmd(8'hD0);
        check(rb_n == 1'b1, "R10 erase opcode mid-address aborts", rb_n, 1);
        cmd(8'h80); page_load(1'b0); cmd(8'h70); cmd(8'h10);
        check(rb_n == 1'b1, "R10 status mid-sequence aborts", rb_n, 1);
        cmd(8'h60); adr(8'h00); dat(8'h33); adr(8'h00); adr(8'h00); cmd(8'hD0);
        check(rb_n == 1'b1, "R10 data cycle in erase address aborts", rb_n, 1);

        // R5 lockout during busy; first force fail bit to 1
        fail_inj = 2'b01;
        cmd(8'h60); adr(8'h00); adr(8'h00); adr(8'h00); cmd(8'hD0); t0 = cyc; wait_rdy(t0, dur);
        exp_fail = 1'b1;
        fail_inj = 2'b00;
        cmd(8'h60); adr(8'h00); adr(8'h00); adr(8'h00); cmd(8'hD0); t0 = cyc;
        cmd(8'h70);
        cmd(8'h80); cmd(8'h60); cmd(8'h10); cmd(8'hD0); cmd(8'h11); cmd(8'h90);
        adr(8'h12); dat(8'h34);
        rd(v);
        check(v == sbyte(1'b0, 1'b1), "R5 status mode kept through ignored bytes", v, sbyte(1'b0, 1'b1));
        wait_rdy(t0, dur);
        check(dur == ERASE, "R5 busy length unchanged", dur, ERASE);
        exp_fail = 1'b0;
        rd(v);
        check(v == sbyte(1'b1, 1'b0), "R5 result after lockout", v, sbyte(1'b1, 1'b0));

        // R11 reset during busy clears fail
        fail_inj = 2'b11;
        cmd(8'h80); page_load(1'b0); cmd(8'h10); t0 = cyc;
        repeat (3) @(negedge clk);
        cmd(8'hFF);
        check(rb_n == 1'b1, "R11 ready after reset command", rb_n, 1);
        rd(v);
        check(v == 8'h00, "R11 reset leaves status mode", v, 8'h00);
        cmd(8'h70); rd(v);
        check(v == 8'h40, "R11 fail cleared", v, 8'h40);
        repeat (PROG) @(negedge clk);
        check(rb_n == 1'b1, "R11 no late busy", rb_n, 1);

        // R12 other command ends status mode
        cmd(8'h90); rd(v);
        check(v == 8'h00, "R12 status mode ended", v, 8'h00);
        cmd(8'h78); rd(v);
        check(v == 8'h40, "R12 R4 status mode re-entered", v, 8'h40);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule